// File: doc/BRIEF.md
# Serial hold pause controller

This unit sits between the already-synchronised pins of a serial memory target and its command engine. It lets a host pause a command in mid-flight by pulling the active-low hold input low. While paused, the unit stops forwarding serial-clock edges to the engine. Because the engine samples its data input only on a forwarded rising edge, data-input activity is ignored as well, and the engine keeps its exact bit position. When the pause is released, the engine carries on from that point. The unit also raises a flag that forces the data output to high impedance.

The controller runs on the system clock and samples the serial clock as a level. Entering and leaving a pause is qualified by that level: a hold request seen while the serial clock is high waits for the clock to be low. Pausing works only in single-lane and dual-lane operation. In quad operation the hold pin carries data, so hold is ignored. Hold is also ignored when the hold-disable bit from the mode register is set. Raising chip select clears any pause.

There is no data stream at this unit's boundary, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level and every output is a registered level or pulse.

Top module: `hold_pause_ctrl`

## Requirements
- R1: During and right after reset, `sck_rise_en`, `sck_fall_en`, `hold_active` and `out_hiz` are all 0.
- R2: With no hold, a sample in which `sck` is 1 after being 0 produces a one-cycle `sck_rise_en` pulse on the next cycle. A sample in which `sck` is 0 after being 1 produces a `sck_fall_en` pulse in the same way.
- R3: When `hold_n` is sampled 0 while `sck` is 0 and hold applies, `hold_active` is 1 on the next cycle.
- R4: When `hold_n` is sampled 0 while `sck` is 1, `hold_active` stays 0. It becomes 1 one cycle after the first sample with `sck` at 0, and the falling edge in that sample is not forwarded.
- R5: Hold ends only in a sample where `hold_n` is 1 and `sck` is 0. If `hold_n` is 1 while `sck` is 1, `hold_active` stays 1.
- R6: No edge enable is produced for a sample in which hold is active, either before or after that sample. This includes the falling edge in the release sample, so the engine resumes on the next rising edge.
- R7: `out_hiz` is 1 one cycle after any sample where `hold_n` is 0 and hold applies, whatever the `sck` level. It is also 1 whenever `hold_active` is 1.
- R8: Hold applies only for `lane_mode` 2'b00 (single) and 2'b01 (dual). For 2'b10 (quad) and 2'b11 (reserved), `hold_n` has no effect: `hold_active` and `out_hiz` stay 0 and edges keep being forwarded.
- R9: When `hold_dis` is 1, `hold_n` has no effect, just as in R8.
- R10: A sample with `cs_n` at 1 clears `hold_active` and `out_hiz` on the next cycle and blocks hold entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Synchronised chip select, active low |
| sck | input | 1 | Synchronised serial clock level |
| hold_n | input | 1 | Synchronised hold request, active low |
| lane_mode | input | 2 | 00 single, 01 dual, 10 quad, 11 reserved |
| hold_dis | input | 1 | Mode-register bit that disables hold when 1 |
| sck_rise_en | output | 1 | Qualified serial-clock rising-edge pulse to the engine |
| sck_fall_en | output | 1 | Qualified serial-clock falling-edge pulse to the engine |
| hold_active | output | 1 | Pause is in force |
| out_hiz | output | 1 | Force the data output to high impedance |

## Verification
Every output is registered once after its inputs are sampled, so each result is due exactly one system clock after the edge that samples the stimulus. The bench changes inputs on a falling system-clock edge and checks outputs on the next falling edge, which catches each result in its single valid cycle. Deferred entry and delayed release are checked as a sequence of such single steps. Each step asserts both the state that must not change yet and the state that must change.

// File: rtl/hold_pkg.sv
package hold_pkg;
  localparam int LANE_W = 2;

  typedef enum logic [LANE_W-1:0] {
    LANE_SINGLE = 2'b00,
    LANE_DUAL   = 2'b01,
    LANE_QUAD   = 2'b10,
    LANE_RSVD   = 2'b11
  } lane_e;
endpackage

// File: rtl/hold_sck_edge.sv
module hold_sck_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  output logic rise_now,
  output logic fall_now
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign rise_now = sck & ~sck_q;
  assign fall_now = ~sck & sck_q;
endmodule

// File: rtl/hold_state.sv
module hold_state
  import hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              hold_n,
  input  logic [LANE_W-1:0] lane_mode,
  input  logic              hold_dis,
  output logic              applies,
  output logic              held,
  output logic              held_nx
);
  logic lane_ok;

  assign lane_ok = (lane_mode == LANE_SINGLE) || (lane_mode == LANE_DUAL);
  assign applies = ~cs_n & lane_ok & ~hold_dis;

  // Enter and leave only at a low serial-clock level.
  always_comb begin
    held_nx = held;
    if (!applies)         held_nx = 1'b0;
    else if (!sck)        held_nx = ~hold_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= held_nx;
  end
endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl
  import hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              hold_n,
  input  logic [LANE_W-1:0] lane_mode,
  input  logic              hold_dis,
  output logic              sck_rise_en,
  output logic              sck_fall_en,
  output logic              hold_active,
  output logic              out_hiz
);
  logic rise_now, fall_now;
  logic applies, held, held_nx;
  logic pass;

  hold_sck_edge i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  hold_state i_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sck       (sck),
    .hold_n    (hold_n),
    .lane_mode (lane_mode),
    .hold_dis  (hold_dis),
    .applies   (applies),
    .held      (held),
    .held_nx   (held_nx)
  );

  // An edge passes only if hold is off both before and after the sample.
  assign pass = ~held & ~held_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_rise_en <= 1'b0;
      sck_fall_en <= 1'b0;
      out_hiz     <= 1'b0;
    end else begin
      sck_rise_en <= rise_now & pass;
      sck_fall_en <= fall_now & pass;
      out_hiz     <= held_nx | (applies & ~hold_n);
    end
  end

  assign hold_active = held;
endmodule

// File: rtl/hold_pause_chk.sv
module hold_pause_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       hold_n,
  input logic [1:0] lane_mode,
  input logic       hold_dis,
  input logic       sck_rise_en,
  input logic       sck_fall_en,
  input logic       hold_active,
  input logic       out_hiz
);
  assert_no_edge_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (!sck_rise_en && !sck_fall_en));

  assert_entry_at_low_sck_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> $past(!sck && !hold_n));

  assert_release_at_low_sck_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> ($past(!sck && hold_n) || $past(cs_n) ||
                            $past(lane_mode[1]) || $past(hold_dis)));

  assert_quad_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lane_mode[1]) |-> (!hold_active && !out_hiz));

  assert_disable_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_dis) |-> (!hold_active && !out_hiz));

  assert_cs_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (!hold_active && !out_hiz));

  assert_hiz_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> out_hiz);

  assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise_en && sck_fall_en));
endmodule

bind hold_pause_ctrl hold_pause_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .sck         (sck),
  .hold_n      (hold_n),
  .lane_mode   (lane_mode),
  .hold_dis    (hold_dis),
  .sck_rise_en (sck_rise_en),
  .sck_fall_en (sck_fall_en),
  .hold_active (hold_active),
  .out_hiz     (out_hiz)
);

// File: tb/test_hold_pause_ctrl.sv
`timescale 1ns/1ps
module test_hold_pause_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       hold_n = 1'b1;
  logic [1:0] lane_mode = 2'b00;
  logic       hold_dis = 1'b0;
  logic       sck_rise_en, sck_fall_en, hold_active, out_hiz;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hold_pause_ctrl i_hold_pause_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .lane_mode(lane_mode), .hold_dis(hold_dis),
    .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en),
    .hold_active(hold_active), .out_hiz(out_hiz)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  // Apply inputs, then wait one clock so registered outputs reflect them.
  task automatic step(input logic c, input logic s, input logic h);
    cs_n = c; sck = s; hold_n = h;
    @(negedge clk);
  endtask

  task automatic expect4(input string req, input logic r, input logic f,
                         input logic a, input logic z);
    chk(req, "sck_rise_en", sck_rise_en, r);
    chk(req, "sck_fall_en", sck_fall_en, f);
    chk(req, "hold_active", hold_active, a);
    chk(req, "out_hiz", out_hiz, z);
  endtask

  task automatic idle();
    lane_mode = 2'b00; hold_dis = 1'b0;
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    expect4("R1", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_forward();
    idle();
    step(1'b0, 1'b0, 1'b1); expect4("R2", 0, 0, 0, 0);
    step(1'b0, 1'b1, 1'b1); expect4("R2", 1, 0, 0, 0);
    step(1'b0, 1'b1, 1'b1); expect4("R2", 0, 0, 0, 0);
    step(1'b0, 1'b0, 1'b1); expect4("R2", 0, 1, 0, 0);
  endtask

  task automatic t_immediate();
    idle();
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0); expect4("R3", 0, 0, 1, 1);
    step(1'b0, 1'b1, 1'b0); expect4("R6", 0, 0, 1, 1);
    step(1'b0, 1'b0, 1'b0); expect4("R6", 0, 0, 1, 1);
    step(1'b0, 1'b0, 1'b1); expect4("R5", 0, 0, 0, 0);
    step(1'b0, 1'b1, 1'b1); expect4("R6", 1, 0, 0, 0);
  endtask

  task automatic t_deferred();
    idle();
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1); expect4("R2", 1, 0, 0, 0);
    step(1'b0, 1'b1, 1'b0); expect4("R4", 0, 0, 0, 1);
    step(1'b0, 1'b0, 1'b0); expect4("R4", 0, 0, 1, 1);
    step(1'b0, 1'b0, 1'b1); expect4("R5", 0, 0, 0, 0);
    step(1'b0, 1'b1, 1'b1); expect4("R5", 1, 0, 0, 0);
  endtask

  task automatic t_release_high();
    idle();
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0); expect4("R3", 0, 0, 1, 1);
    step(1'b0, 1'b1, 1'b0); expect4("R6", 0, 0, 1, 1);
    step(1'b0, 1'b1, 1'b1); expect4("R5", 0, 0, 1, 1);
    step(1'b0, 1'b0, 1'b1); expect4("R6", 0, 0, 0, 0);
    step(1'b0, 1'b1, 1'b1); expect4("R6", 1, 0, 0, 0);
  endtask

  task automatic t_quad();
    for (int m = 2; m < 4; m++) begin
      idle();
      lane_mode = 2'(m);
      step(1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b0); expect4("R8", 0, 0, 0, 0);
      step(1'b0, 1'b1, 1'b0); expect4("R8", 1, 0, 0, 0);
      step(1'b0, 1'b0, 1'b0); expect4("R8", 0, 1, 0, 0);
    end
    idle();
    lane_mode = 2'b01;
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0); expect4("R8", 0, 0, 1, 1);
  endtask

  task automatic t_disable();
    idle();
    hold_dis = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0); expect4("R9", 0, 0, 0, 0);
    step(1'b0, 1'b1, 1'b0); expect4("R9", 1, 0, 0, 0);
    step(1'b0, 1'b0, 1'b0); expect4("R9", 0, 1, 0, 0);
  endtask

  task automatic t_cs();
    idle();
    step(1'b1, 1'b0, 1'b0); expect4("R10", 0, 0, 0, 0);
    step(1'b0, 1'b0, 1'b0); expect4("R10", 0, 0, 1, 1);
    step(1'b1, 1'b0, 1'b0); expect4("R10", 0, 0, 0, 0);
    step(1'b1, 1'b1, 1'b1); expect4("R10", 1, 0, 0, 0);
  endtask

  task automatic t_hiz_any_phase();
    idle();
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0); expect4("R7", 0, 0, 0, 1);
    step(1'b0, 1'b1, 1'b1); expect4("R7", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_immediate();
    t_deferred();
    t_release_high();
    t_hiz_any_phase();
    t_quad();
    t_disable();
    t_cs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule